// File: doc/BRIEF.md
# Page-mode parallel ROM read controller

This block sits on the host side of a parallel asynchronous mask ROM that supports page access. It takes one read at a time from a valid/ready request port, together with a flag that selects 16-bit word or 8-bit byte width. It drives the ROM chip-enable, output-enable, width-select and address pins. It then counts clock cycles that stand in for the ROM access times, samples the data pins and returns the result as a one-cycle response pulse.

The controller remembers which page the ROM currently has open: the upper address pins, the width mode, and whether chip-enable has stayed on. A read whose upper address pins and mode match the open page only changes the in-page bits and waits the short page time. Every other read waits the full access time, which also covers the chip-enable, output-enable and width-switch settling times. In byte mode the ROM's top data pin becomes the lowest address input, so the controller drives it. In word mode it releases that pin and reads it as data bit 15. The output-enable pin polarity is chosen by parameter. After a run of idle cycles the controller drops chip-enable, which closes the page.

Top module: `pgrom_rd_ctrl`

## Requirements
- R1: While reset is applied and right after it, rom_ce_n is 1, output-enable is inactive, req_ready is 1, rsp_valid is 0, rom_word is 1 and rom_d15_oe is 0.
- R2: Only one read is outstanding. req_ready falls after an accepted request and stays low through the one-cycle rsp_valid pulse. It is high again in the cycle after the pulse, so a waiting request is accepted on the second rising edge after the edge that raised rsp_valid.
- R3: A read that misses the open page raises rsp_valid at exactly the FULL_CYC-th rising edge after the accepting edge. FULL_CYC is the largest of T_ACC_CYC, T_MODE_CYC and T_OE_CYC (10 by default).
- R4: A read with the same mode and the same upper address pins as the open page, while chip-enable has stayed on, raises rsp_valid T_PAGE_CYC edges (3 by default) after acceptance.
- R5: Byte mode (req_word=0): rom_word is 0, rom_addr equals req_addr[ADDR_W:1], rom_d15_oe is 1, rom_d15_out equals req_addr[0], and rsp_data is zero in bits 15..8 with data pins 7..0 in bits 7..0.
- R6: Word mode (req_word=1): rom_word is 1, rom_addr equals req_addr[ADDR_W-1:0], rom_d15_oe is 0, and rsp_data carries all 16 data pins, including pin 15.
- R7: A read whose mode differs from the previous read always takes the full wait, even when its upper address pins match.
- R8: Output-enable is asserted together with chip-enable and never without it. With OE_ACT_LOW the enabled pin level is 0; with OE_ACT_HIGH it is 1; with OE_UNUSED the pin is held at 0.
- R9: After IDLE_CYC consecutive idle cycles (8 by default), chip-enable and output-enable are released, and the next read takes the full wait. A gap shorter than that keeps the page open.
- R10: rom_addr, rom_word and rom_d15_out do not change from acceptance until the response pulse.
- R11: A byte-mode page is the 8 bytes sharing req_addr[ADDR_W:3]. A word-mode page is the 4 words sharing req_addr[ADDR_W-1:2]. A read that crosses such a boundary takes the full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W+1 | Byte address (byte mode) or word address in the low ADDR_W bits (word mode) |
| req_word | input | 1 | 1 selects 16-bit word mode, 0 selects byte mode |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | DATA_W | Read result |
| rom_ce_n | output | 1 | ROM chip-enable, active low |
| rom_oe | output | 1 | ROM output-enable pin, polarity set by OE_POL |
| rom_word | output | 1 | ROM width select, 1 for word mode |
| rom_addr | output | ADDR_W | ROM address pins A0 and up |
| rom_d_in | input | DATA_W | ROM data pins as seen by the controller |
| rom_d15_out | output | 1 | Value driven on the shared data-15 / address-LSB pin |
| rom_d15_oe | output | 1 | Drive enable for the shared pin (byte mode) |

## Verification
A behavioural ROM model in the bench returns a junk pattern until each access timer it keeps has run out: address, page, output-enable and width switch. Any early sample therefore shows up as wrong data, and any late one shows up as a wrong latency. Reads are tried as word-mode misses and in-page hits, byte-mode hits that only toggle the shared LSB pin, and crossings of the 4-word and 8-byte boundaries. Further patterns are mode switches onto an address in the already-open page, and short and long idle gaps. Together these separate page-hit detection, width handling, mode-change invalidation and chip-enable release. Two extra instances with the other output-enable polarities show the pin levels each setting produces.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;

   typedef enum logic [1:0] {
      OE_ACT_LOW  = 2'd0,
      OE_ACT_HIGH = 2'd1,
      OE_UNUSED   = 2'd2
   } oe_pol_e;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pgrom_wait_timer.sv
module pgrom_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             running,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         cnt_q <= load_val;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign running = run_q;
   assign expire  = run_q && (cnt_q == '0);

endmodule

// File: rtl/pgrom_page_tag.sv
module pgrom_page_tag #(
   parameter int UP_W = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            load,
   input  logic [UP_W-1:0] upper_in,
   input  logic            mode_in,
   output logic            hit
);

   logic            vld_q;
   logic [UP_W-1:0] tag_q;
   logic            mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         tag_q  <= '0;
         mode_q <= 1'b1;
      end else if (load) begin
         vld_q  <= 1'b1;
         tag_q  <= upper_in;
         mode_q <= mode_in;
      end else if (clr) begin
         vld_q  <= 1'b0;
      end
   end

   assign hit = vld_q && (tag_q == upper_in) && (mode_q == mode_in);

endmodule

// File: rtl/pgrom_pin_drv.sv
module pgrom_pin_drv
   import pgrom_pkg::*;
#(
   parameter oe_pol_e OE_POL = OE_ACT_LOW,
   parameter int      DATA_W = 16
) (
   input  logic              oe_act,
   input  logic              word_md,
   input  logic              a_lsb,
   input  logic [DATA_W-1:0] d_in,
   output logic              rom_oe,
   output logic              d15_out,
   output logic              d15_oe,
   output logic [DATA_W-1:0] rd_data
);

   localparam int BYTE_W = DATA_W / 2;

   generate
      if (OE_POL == OE_ACT_LOW) begin : g_oe_low
         assign rom_oe = ~oe_act;
      end else if (OE_POL == OE_ACT_HIGH) begin : g_oe_high
         assign rom_oe = oe_act;
      end else begin : g_oe_none
         logic unused_oe;
         assign unused_oe = oe_act;
         assign rom_oe    = 1'b0;
      end
   endgenerate

   assign d15_oe  = ~word_md;
   assign d15_out = word_md ? 1'b0 : a_lsb;

   always_comb begin
      if (word_md) rd_data = d_in;
      else         rd_data = {{(DATA_W - BYTE_W){1'b0}}, d_in[BYTE_W-1:0]};
   end

endmodule

// File: rtl/pgrom_rd_ctrl.sv
module pgrom_rd_ctrl
   import pgrom_pkg::*;
#(
   parameter int      ADDR_W     = 23,
   parameter int      DATA_W     = 16,
   parameter int      PG_W       = 2,
   parameter int      T_ACC_CYC  = 10,
   parameter int      T_PAGE_CYC = 3,
   parameter int      T_OE_CYC   = 3,
   parameter int      T_MODE_CYC = 10,
   parameter int      IDLE_CYC   = 8,
   parameter oe_pol_e OE_POL     = OE_ACT_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W:0]   req_addr,
   input  logic              req_word,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rom_ce_n,
   output logic              rom_oe,
   output logic              rom_word,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_d_in,
   output logic              rom_d15_out,
   output logic              rom_d15_oe
);

   localparam int FULL_CYC = int'(max3(T_ACC_CYC, T_MODE_CYC, T_OE_CYC));
   localparam int CNT_W    = $clog2(FULL_CYC + 1);
   localparam int UP_W     = ADDR_W - PG_W;
   localparam int IDLE_W   = $clog2(IDLE_CYC + 1);

   generate
      if (T_PAGE_CYC < 1 || T_PAGE_CYC > FULL_CYC) begin : g_bad_page
         $error("page wait must lie between 1 and the full wait");
      end
      if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_data
         $error("data width must be even");
      end
      if (PG_W < 1 || PG_W >= ADDR_W) begin : g_bad_pg
         $error("page index width out of range");
      end
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("idle limit must be at least one cycle");
      end
   endgenerate

   // registered pin state
   logic              ce_on_q, oe_on_q, word_q, lsb_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rsp_vld_q;
   logic [DATA_W-1:0] rsp_dat_q;
   logic [IDLE_W-1:0] idle_q;

   logic              busy, expire, accept, hit, release_ce;
   logic [ADDR_W-1:0] new_addr;
   logic [CNT_W-1:0]  wait_val;
   logic [DATA_W-1:0] rd_fmt;

   assign req_ready = !busy && !rsp_vld_q;
   assign accept    = req_valid && req_ready;
   assign new_addr  = req_word ? req_addr[ADDR_W-1:0] : req_addr[ADDR_W:1];
   assign wait_val  = hit ? CNT_W'(T_PAGE_CYC - 1) : CNT_W'(FULL_CYC - 1);

   assign release_ce = ce_on_q && !busy && !accept &&
                       (idle_q == IDLE_W'(IDLE_CYC - 1));

   pgrom_page_tag #(.UP_W(UP_W)) u_tag (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (release_ce),
      .load     (accept),
      .upper_in (new_addr[ADDR_W-1:PG_W]),
      .mode_in  (req_word),
      .hit      (hit)
   );

   pgrom_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (wait_val),
      .running  (busy),
      .expire   (expire)
   );

   pgrom_pin_drv #(.OE_POL(OE_POL), .DATA_W(DATA_W)) u_pins (
      .oe_act  (oe_on_q),
      .word_md (word_q),
      .a_lsb   (lsb_q),
      .d_in    (rom_d_in),
      .rom_oe  (rom_oe),
      .d15_out (rom_d15_out),
      .d15_oe  (rom_d15_oe),
      .rd_data (rd_fmt)
   );

   // pin control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_on_q <= 1'b0;
         oe_on_q <= 1'b0;
         word_q  <= 1'b1;
         lsb_q   <= 1'b0;
         addr_q  <= '0;
      end else if (accept) begin
         ce_on_q <= 1'b1;
         oe_on_q <= 1'b1;
         word_q  <= req_word;
         lsb_q   <= req_word ? 1'b0 : req_addr[0];
         addr_q  <= new_addr;
      end else if (release_ce) begin
         ce_on_q <= 1'b0;
         oe_on_q <= 1'b0;
      end
   end

   // idle run length while the chip stays selected
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          idle_q <= '0;
      else if (accept || busy || !ce_on_q) idle_q <= '0;
      else if (!release_ce)                idle_q <= idle_q + 1'b1;
      else                                 idle_q <= '0;
   end

   // response capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld_q <= 1'b0;
         rsp_dat_q <= '0;
      end else begin
         rsp_vld_q <= expire;
         if (expire) rsp_dat_q <= rd_fmt;
      end
   end

   assign rsp_valid = rsp_vld_q;
   assign rsp_data  = rsp_dat_q;
   assign rom_ce_n  = ~ce_on_q;
   assign rom_word  = word_q;
   assign rom_addr  = addr_q;

endmodule

// File: rtl/pgrom_rd_chk.sv
module pgrom_rd_chk
   import pgrom_pkg::*;
#(
   parameter int      ADDR_W = 23,
   parameter oe_pol_e OE_POL = OE_ACT_LOW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rom_ce_n,
   input logic              rom_oe,
   input logic              rom_word,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              rom_d15_out,
   input logic              rom_d15_oe
);

   logic busy;
   assign busy = !req_ready && !rsp_valid;

   a_r2_ready_low_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_ce_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !rom_ce_n);

   a_r10_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(rom_addr) && $stable(rom_word) &&
                                 $stable(rom_d15_out)));

   a_r5_d15_drive_mode: assert property (@(posedge clk) disable iff (!rst_n)
      rom_d15_oe |-> !rom_word);

   generate
      if (OE_POL == OE_ACT_LOW) begin : g_low
         a_r8_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
            !rom_oe |-> !rom_ce_n);
      end else if (OE_POL == OE_ACT_HIGH) begin : g_high
         a_r8_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
            rom_oe |-> !rom_ce_n);
      end else begin : g_none
         a_r8_oe_tied: assert property (@(posedge clk) disable iff (!rst_n)
            !rom_oe);
      end
   endgenerate

endmodule

bind pgrom_rd_ctrl pgrom_rd_chk #(.ADDR_W(ADDR_W), .OE_POL(OE_POL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .rom_ce_n    (rom_ce_n),
   .rom_oe      (rom_oe),
   .rom_word    (rom_word),
   .rom_addr    (rom_addr),
   .rom_d15_out (rom_d15_out),
   .rom_d15_oe  (rom_d15_oe)
);

// File: tb/tb_pgrom_rd_ctrl.sv
module tb_pgrom_rd_ctrl;
   import pgrom_pkg::*;

   localparam int FULL = 10;
   localparam int PAGE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_word = 1'b1;
   logic        req_ready, rsp_valid, rom_ce_n, rom_oe, rom_word, rom_d15_out, rom_d15_oe;
   logic [15:0] rsp_data;
   logic [22:0] rom_addr;
   logic [15:0] rom_d_in = 16'h0BAD;

   logic        h_rdy, h_rv, h_ce, h_oe, h_wd, h_d15, h_d15oe;
   logic [15:0] h_rd;
   logic [22:0] h_addr;
   logic        n_rdy, n_rv, n_ce, n_oe, n_wd, n_d15, n_d15oe;
   logic [15:0] n_rd;
   logic [22:0] n_addr;

   always #5 clk = ~clk;

   pgrom_rd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_word(req_word), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rom_ce_n(rom_ce_n), .rom_oe(rom_oe), .rom_word(rom_word),
      .rom_addr(rom_addr), .rom_d_in(rom_d_in), .rom_d15_out(rom_d15_out),
      .rom_d15_oe(rom_d15_oe));

   pgrom_rd_ctrl #(.OE_POL(OE_ACT_HIGH)) dut_hi (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(h_rdy),
      .req_addr(req_addr), .req_word(req_word), .rsp_valid(h_rv),
      .rsp_data(h_rd), .rom_ce_n(h_ce), .rom_oe(h_oe), .rom_word(h_wd),
      .rom_addr(h_addr), .rom_d_in(rom_d_in), .rom_d15_out(h_d15),
      .rom_d15_oe(h_d15oe));

   pgrom_rd_ctrl #(.OE_POL(OE_UNUSED)) dut_nc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_rdy),
      .req_addr(req_addr), .req_word(req_word), .rsp_valid(n_rv),
      .rsp_data(n_rd), .rom_ce_n(n_ce), .rom_oe(n_oe), .rom_word(n_wd),
      .rom_addr(n_addr), .rom_d_in(rom_d_in), .rom_d15_out(n_d15),
      .rom_d15_oe(n_d15oe));

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int last_rsp_cyc = -100;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] rom_val(input logic [22:0] wa);
      return {wa[7:0] ^ 8'hA5, wa[15:8] ^ {1'b0, wa[22:16]} ^ 8'h3C};
   endfunction

   // ROM model: junk until every access timer has elapsed
   int          acc_age, pg_age, oe_age;
   logic        p_ce_n, p_oe, p_word, p_lsb;
   logic [22:0] p_addr;

   always @(negedge clk) begin
      logic ok;
      logic [15:0] wv;
      if (!rst_n) begin
         acc_age = 0; pg_age = 0; oe_age = 0;
         p_ce_n = 1'b1; p_oe = 1'b1; p_word = 1'b1; p_lsb = 1'b0; p_addr = '0;
         rom_d_in = 16'h0BAD;
      end else begin
         if (rom_ce_n) acc_age = 0;
         else if (p_ce_n || rom_addr[22:2] != p_addr[22:2] || rom_word != p_word) acc_age = 1;
         else if (acc_age < 1000) acc_age++;
         if (rom_addr[1:0] != p_addr[1:0] || (!rom_word && rom_d15_out != p_lsb)) pg_age = 1;
         else if (pg_age < 1000) pg_age++;
         if (rom_oe) oe_age = 0;
         else if (p_oe) oe_age = 1;
         else if (oe_age < 1000) oe_age++;
         p_ce_n = rom_ce_n; p_oe = rom_oe; p_word = rom_word; p_lsb = rom_d15_out; p_addr = rom_addr;
         ok = !rom_ce_n && !rom_oe && acc_age >= FULL && pg_age >= PAGE && oe_age >= PAGE &&
              (rom_word != rom_d15_oe);
         wv = rom_val(rom_addr);
         if (!ok)           rom_d_in = 16'h0BAD;
         else if (rom_word) rom_d_in = wv;
         else               rom_d_in = {8'hEE, rom_d15_out ? wv[15:8] : wv[7:0]};
      end
   end

   // scoreboard
   typedef struct {
      logic [15:0] d;
      int          lat;
      int          acc;
      logic [22:0] pa;
      string       rq;
   } item_t;
   item_t sb_q[$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R2 unexpected response actual=%0h expected=none", rsp_data);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            chk({it.rq, " data"}, 32'(rsp_data), 32'(it.d));
            chk({it.rq, " latency"}, 32'(cyc - it.acc), 32'(it.lat));
            chk("R10 address held to response", 32'(rom_addr), 32'(it.pa));
            last_rsp_cyc = cyc;
         end
      end
   end

   // bench view of the open page
   logic        pv = 1'b0;
   logic [20:0] pup = '0;
   logic        pmd = 1'b1;

   task automatic rd(input logic [23:0] a, input logic wd, input bit b2b, input string rq);
      item_t it;
      logic [15:0] wv;
      logic [22:0] pa;
      pa = wd ? a[22:0] : a[23:1];
      wv = rom_val(pa);
      it.d   = wd ? wv : {8'h00, a[0] ? wv[15:8] : wv[7:0]};
      it.lat = (!pv || pmd != wd || pup != pa[22:2]) ? FULL : PAGE;
      it.pa  = pa;
      it.rq  = rq;
      pv = 1'b1; pmd = wd; pup = pa[22:2];
      req_addr = a; req_word = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      it.acc = cyc;
      req_valid = 1'b0;
      sb_q.push_back(it);
      chk("R2 ready low while busy", 32'(req_ready), 32'd0);
      if (b2b) chk("R2 accept two edges after pulse", 32'(it.acc), 32'(last_rsp_cyc + 2));
      chk("R10 address pins", 32'(rom_addr), 32'(pa));
      chk("R8 chip enable on", 32'(rom_ce_n), 32'd0);
      chk("R8 active-low enable", 32'(rom_oe), 32'd0);
      chk("R8 active-high enable", 32'(h_oe), 32'd1);
      chk("R8 unused enable tied", 32'(n_oe), 32'd0);
      if (wd) begin
         chk("R6 width pin", 32'(rom_word), 32'd1);
         chk("R6 shared pin released", 32'(rom_d15_oe), 32'd0);
      end else begin
         chk("R5 width pin", 32'(rom_word), 32'd0);
         chk("R5 shared pin driven", 32'(rom_d15_oe), 32'd1);
         chk("R5 shared pin carries LSB", 32'(rom_d15_out), 32'(a[0]));
      end
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 chip enable off", 32'(rom_ce_n), 32'd1);
      chk("R1 enable inactive", 32'(rom_oe), 32'd1);
      chk("R1 ready", 32'(req_ready), 32'd1);
      chk("R1 no response", 32'(rsp_valid), 32'd0);
      chk("R1 word mode", 32'(rom_word), 32'd1);
      chk("R1 shared pin released", 32'(rom_d15_oe), 32'd0);
      chk("R8 active-high idle", 32'(h_oe), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", 32'(req_ready), 32'd1);

      // word mode: first miss then in-page hits
      rd(24'h01234, 1'b1, 1'b0, "R3 R6 first word miss");
      rd(24'h01235, 1'b1, 1'b1, "R4 word hit");
      rd(24'h01237, 1'b1, 1'b1, "R4 word hit top of page");
      rd(24'h01236, 1'b1, 1'b1, "R4 word hit reverse");
      rd(24'h01238, 1'b1, 1'b1, "R11 word page crossing");
      rd(24'h7F080, 1'b1, 1'b1, "R3 word far miss");
      // byte mode
      rd(24'h002469, 1'b0, 1'b1, "R7 R5 mode change to byte");
      rd(24'h002468, 1'b0, 1'b1, "R4 R5 byte hit LSB only");
      rd(24'h00246F, 1'b0, 1'b1, "R4 R5 byte hit page top");
      rd(24'h002470, 1'b0, 1'b1, "R11 byte page crossing");
      rd(24'h002475, 1'b0, 1'b1, "R4 R5 byte hit");
      // back to word on an address inside the open page
      rd(24'h01239, 1'b1, 1'b1, "R7 mode change to word");
      drain();

      // short gap keeps the page open
      repeat (3) @(negedge clk);
      chk("R9 short gap keeps chip on", 32'(rom_ce_n), 32'd0);
      rd(24'h0123A, 1'b1, 1'b0, "R9 hit after short gap");
      drain();

      // long gap releases chip enable
      repeat (12) @(negedge clk);
      chk("R9 chip enable released", 32'(rom_ce_n), 32'd1);
      chk("R9 enable released", 32'(rom_oe), 32'd1);
      chk("R9 active-high released", 32'(h_oe), 32'd0);
      pv = 1'b0;
      rd(24'h0123B, 1'b1, 1'b0, "R9 miss after release");
      drain();
      repeat (2) @(negedge clk);

      summary();
      $finish;
   end

endmodule